// File: doc/BRIEF.md
# Banked Draw-State Register File

This block is a small control-register file that keeps per-group drawing state for up to 32 groups. Software (or a command processor) configures a group by writing a combined header word that carries the group index, a 3-bit mode mask and a 16-bit dword count. The same write marks the group as active in a bitmask. Later writes to two base-address halves land in whichever group the most recent header word named.

A select write makes one group current. In a single clock edge the block exposes that group's header and 64-bit base through read-only view registers. It also swaps the live streaming-context registers: the live 64-bit context base and dword count are stored into the group that was current before, and the new group's stored pair is loaded. All registers sit behind a plain address / write-data / write-enable / read-data port. Reads are combinational and have no side effects.

Top module: `ds_regfile`

## Requirements
- R1: After reset every readable register reads 0, and every group's stored header, base and context pair are 0.
- R2: A write to address 0 with index in bits 28:24, mode in bits 22:20 and count in bits 15:0 stores that group's header as {3'b0, index, 1'b0, mode, 4'b0, count}, replacing any earlier header for that group.
- R3: A write to address 0 sets bit `index` of the active mask (address 2) and leaves every other bit unchanged.
- R4: A write to address 2 loads the active mask directly from the write data.
- R5: Writes to address 6 (low half) and address 7 (high half) update the base of the group named by bits 28:24 of the last value written to address 0. Reads of addresses 6 and 7 return that group's stored base halves.
- R6: A write to address 1 makes the header view (address 3) and the base view (addresses 4 low, 5 high) show the selected group's stored values in the next cycle.
- R7: On a write to address 1, the live context base (address 8 low, 9 high) and the live dword count (address 10) are saved into the group selected before that write.
- R8: After that save, addresses 8, 9 and 10 hold the values stored for the newly selected group, and address 1 reads back the new index.
- R9: Selecting the group that is already selected leaves the live context registers unchanged.
- R10: Only bits 4:0 of a select write form the index. Higher bits are dropped and do not read back.
- R11: Reads change no state. Writes to the view addresses 3, 4 and 5 are ignored. Addresses 11 to 15 read 0 and ignore writes.
- R12: Address 0 reads back the full 32-bit value last written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 4 | Register address |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write enable, one write per cycle |
| rdata_o | output | 32 | Combinational read data for addr_i |

## Verification
A single select write both saves the live context into the previous group and restores the next group's context. When the two groups are the same, save and restore meet on the same storage entry in the same edge. The bench provokes this by writing a new dword count while a group is selected, then selecting that same group again. The live count must read back unchanged, and a later select away and back must return it as well.

// File: rtl/ds_regfile_pkg.sv
package ds_regfile_pkg;

  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned IDX_LSB  = 24;
  localparam int unsigned MODE_LSB = 20;
  localparam int unsigned MODE_W   = 3;
  localparam int unsigned CNT_W    = 16;

  typedef enum logic [ADDR_W-1:0] {
    A_SET_HDR  = 4'd0,
    A_SEL      = 4'd1,
    A_ACTIVE   = 4'd2,
    A_HDR_VIEW = 4'd3,
    A_BASE_LO  = 4'd4,
    A_BASE_HI  = 4'd5,
    A_GBASE_LO = 4'd6,
    A_GBASE_HI = 4'd7,
    A_CTX_LO   = 4'd8,
    A_CTX_HI   = 4'd9,
    A_CTX_DW   = 4'd10
  } reg_addr_e;

  typedef struct packed {
    logic set_hdr;
    logic sel;
    logic active;
    logic gbase_lo;
    logic gbase_hi;
    logic ctx_lo;
    logic ctx_hi;
    logic ctx_dw;
  } wr_strb_t;

  // rebuild a header word in the same layout as the set-header write
  function automatic logic [DATA_W-1:0] pack_hdr(input logic [DATA_W-1:0] w);
    logic [DATA_W-1:0] h;
    h = '0;
    h[IDX_LSB +: 5]       = w[IDX_LSB +: 5];
    h[MODE_LSB +: MODE_W] = w[MODE_LSB +: MODE_W];
    h[CNT_W-1:0]          = w[CNT_W-1:0];
    return h;
  endfunction

endpackage

// File: rtl/ds_wr_decode.sv
module ds_wr_decode
  import ds_regfile_pkg::*;
(
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output wr_strb_t          strb_o
);

  always_comb begin
    strb_o = '0;
    if (we_i) begin
      unique case (addr_i)
        A_SET_HDR:  strb_o.set_hdr  = 1'b1;
        A_SEL:      strb_o.sel      = 1'b1;
        A_ACTIVE:   strb_o.active   = 1'b1;
        A_GBASE_LO: strb_o.gbase_lo = 1'b1;
        A_GBASE_HI: strb_o.gbase_hi = 1'b1;
        A_CTX_LO:   strb_o.ctx_lo   = 1'b1;
        A_CTX_HI:   strb_o.ctx_hi   = 1'b1;
        A_CTX_DW:   strb_o.ctx_dw   = 1'b1;
        default:    strb_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/ds_group_bank.sv
module ds_group_bank
  import ds_regfile_pkg::*;
#(
  parameter int unsigned NUM_GRP = 32,
  localparam int unsigned IDX_W  = $clog2(NUM_GRP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  // header / base configuration
  input  logic              hdr_we_i,
  input  logic [IDX_W-1:0]  hdr_idx_i,
  input  logic [DATA_W-1:0] hdr_wdata_i,
  input  logic              base_lo_we_i,
  input  logic              base_hi_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [DATA_W-1:0] base_wdata_i,
  output logic [63:0]       cfg_base_o,
  // select swap
  input  logic              sel_we_i,
  input  logic [IDX_W-1:0]  sel_idx_i,
  input  logic [IDX_W-1:0]  prev_idx_i,
  input  logic [63:0]       live_cbase_i,
  input  logic [DATA_W-1:0] live_cdw_i,
  output logic [DATA_W-1:0] sel_hdr_o,
  output logic [63:0]       sel_base_o,
  output logic [63:0]       sel_cbase_o,
  output logic [DATA_W-1:0] sel_cdw_o
);

  logic [DATA_W-1:0] hdr_q   [NUM_GRP];
  logic [63:0]       base_q  [NUM_GRP];
  logic [63:0]       cbase_q [NUM_GRP];
  logic [DATA_W-1:0] cdw_q   [NUM_GRP];

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic hit_hdr, hit_cfg, hit_save;
    assign hit_hdr  = hdr_we_i && (hdr_idx_i == IDX_W'(g));
    assign hit_cfg  = (cfg_idx_i == IDX_W'(g));
    assign hit_save = sel_we_i && (prev_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hdr_q[g]   <= '0;
        base_q[g]  <= '0;
        cbase_q[g] <= '0;
        cdw_q[g]   <= '0;
      end else begin
        if (hit_hdr) hdr_q[g] <= pack_hdr(hdr_wdata_i);
        if (hit_cfg && base_lo_we_i) base_q[g][31:0]  <= base_wdata_i;
        if (hit_cfg && base_hi_we_i) base_q[g][63:32] <= base_wdata_i;
        if (hit_save) begin
          cbase_q[g] <= live_cbase_i;
          cdw_q[g]   <= live_cdw_i;
        end
      end
    end
  end

  logic same_grp;
  assign same_grp = (sel_idx_i == prev_idx_i);

  assign cfg_base_o  = base_q[cfg_idx_i];
  assign sel_hdr_o   = hdr_q[sel_idx_i];
  assign sel_base_o  = base_q[sel_idx_i];
  // re-selecting the current group: stored copy is stale, forward live values
  assign sel_cbase_o = same_grp ? live_cbase_i : cbase_q[sel_idx_i];
  assign sel_cdw_o   = same_grp ? live_cdw_i   : cdw_q[sel_idx_i];

  // R7
  save_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_we_i |=> cbase_q[$past(prev_idx_i)] == $past(live_cbase_i));

  // R7
  save_dw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_we_i |=> cdw_q[$past(prev_idx_i)] == $past(live_cdw_i));

  // R2
  hdr_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_we_i |=> hdr_q[$past(hdr_idx_i)][15:0] == $past(hdr_wdata_i[15:0]));

endmodule

// File: rtl/ds_live_ctx.sv
module ds_live_ctx
  import ds_regfile_pkg::*;
#(
  parameter int unsigned NUM_GRP = 32,
  localparam int unsigned IDX_W  = $clog2(NUM_GRP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  wr_strb_t          strb_i,
  input  logic [DATA_W-1:0] wdata_i,
  // from bank: selected group contents
  input  logic [DATA_W-1:0] new_hdr_i,
  input  logic [63:0]       new_base_i,
  input  logic [63:0]       new_cbase_i,
  input  logic [DATA_W-1:0] new_cdw_i,
  output logic [DATA_W-1:0] set_hdr_o,
  output logic [IDX_W-1:0]  cfg_idx_o,
  output logic [IDX_W-1:0]  sel_idx_o,
  output logic [NUM_GRP-1:0] active_o,
  output logic [DATA_W-1:0] hdr_view_o,
  output logic [63:0]       base_view_o,
  output logic [63:0]       cbase_o,
  output logic [DATA_W-1:0] cdw_o
);

  logic [DATA_W-1:0]  set_hdr_q;
  logic [IDX_W-1:0]   sel_q;
  logic [NUM_GRP-1:0] active_q;
  logic [DATA_W-1:0]  hdr_view_q;
  logic [63:0]        base_view_q;
  logic [63:0]        cbase_q;
  logic [DATA_W-1:0]  cdw_q;

  logic [IDX_W-1:0] wr_idx;
  assign wr_idx = wdata_i[IDX_LSB +: IDX_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_hdr_q   <= '0;
      sel_q       <= '0;
      active_q    <= '0;
      hdr_view_q  <= '0;
      base_view_q <= '0;
      cbase_q     <= '0;
      cdw_q       <= '0;
    end else begin
      // set-header update wins over a direct mask write
      if (strb_i.set_hdr) begin
        set_hdr_q <= wdata_i;
        active_q  <= active_q | (NUM_GRP'(1) << wr_idx);
      end else if (strb_i.active) begin
        active_q  <= wdata_i[NUM_GRP-1:0];
      end

      if (strb_i.sel) begin
        sel_q       <= wdata_i[IDX_W-1:0];
        hdr_view_q  <= new_hdr_i;
        base_view_q <= new_base_i;
        cbase_q     <= new_cbase_i;
        cdw_q       <= new_cdw_i;
      end else begin
        if (strb_i.ctx_lo) cbase_q[31:0]  <= wdata_i;
        if (strb_i.ctx_hi) cbase_q[63:32] <= wdata_i;
        if (strb_i.ctx_dw) cdw_q          <= wdata_i;
      end
    end
  end

  assign set_hdr_o   = set_hdr_q;
  assign cfg_idx_o   = set_hdr_q[IDX_LSB +: IDX_W];
  assign sel_idx_o   = sel_q;
  assign active_o    = active_q;
  assign hdr_view_o  = hdr_view_q;
  assign base_view_o = base_view_q;
  assign cbase_o     = cbase_q;
  assign cdw_o       = cdw_q;

  // R3
  act_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_i.set_hdr |=> active_q[$past(wr_idx)]);

  // R3
  act_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_i.set_hdr |=> ((active_q & $past(active_q)) == $past(active_q))
                       && ($countones(active_q ^ $past(active_q)) <= 1));

  // R8
  prev_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_i.sel |=> sel_q == $past(wdata_i[IDX_W-1:0]));

  // R9
  same_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb_i.sel && (wdata_i[IDX_W-1:0] == sel_q)) |=>
      (cdw_q == $past(cdw_q)) && (cbase_q == $past(cbase_q)));

  // R11
  read_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(active_q) && $stable(cdw_q) && $stable(cbase_q)
              && $stable(sel_q) && $stable(set_hdr_q));

endmodule

// File: rtl/ds_regfile.sv
module ds_regfile
  import ds_regfile_pkg::*;
#(
  parameter int unsigned NUM_GRP = 32,
  localparam int unsigned IDX_W  = $clog2(NUM_GRP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o
);

  wr_strb_t           strb;
  logic [DATA_W-1:0]  set_hdr, hdr_view, cdw, new_hdr, new_cdw;
  logic [IDX_W-1:0]   cfg_idx, sel_idx;
  logic [NUM_GRP-1:0] active;
  logic [63:0]        base_view, cbase, cfg_base, new_base, new_cbase;

  ds_wr_decode u_dec (
    .we_i   (we_i),
    .addr_i (addr_i),
    .strb_o (strb)
  );

  ds_group_bank #(.NUM_GRP(NUM_GRP)) u_bank (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hdr_we_i     (strb.set_hdr),
    .hdr_idx_i    (wdata_i[IDX_LSB +: IDX_W]),
    .hdr_wdata_i  (wdata_i),
    .base_lo_we_i (strb.gbase_lo),
    .base_hi_we_i (strb.gbase_hi),
    .cfg_idx_i    (cfg_idx),
    .base_wdata_i (wdata_i),
    .cfg_base_o   (cfg_base),
    .sel_we_i     (strb.sel),
    .sel_idx_i    (wdata_i[IDX_W-1:0]),
    .prev_idx_i   (sel_idx),
    .live_cbase_i (cbase),
    .live_cdw_i   (cdw),
    .sel_hdr_o    (new_hdr),
    .sel_base_o   (new_base),
    .sel_cbase_o  (new_cbase),
    .sel_cdw_o    (new_cdw)
  );

  ds_live_ctx #(.NUM_GRP(NUM_GRP)) u_ctx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (we_i),
    .strb_i      (strb),
    .wdata_i     (wdata_i),
    .new_hdr_i   (new_hdr),
    .new_base_i  (new_base),
    .new_cbase_i (new_cbase),
    .new_cdw_i   (new_cdw),
    .set_hdr_o   (set_hdr),
    .cfg_idx_o   (cfg_idx),
    .sel_idx_o   (sel_idx),
    .active_o    (active),
    .hdr_view_o  (hdr_view),
    .base_view_o (base_view),
    .cbase_o     (cbase),
    .cdw_o       (cdw)
  );

  always_comb begin
    unique case (addr_i)
      A_SET_HDR:  rdata_o = set_hdr;
      A_SEL:      rdata_o = DATA_W'(sel_idx);
      A_ACTIVE:   rdata_o = DATA_W'(active);
      A_HDR_VIEW: rdata_o = hdr_view;
      A_BASE_LO:  rdata_o = base_view[31:0];
      A_BASE_HI:  rdata_o = base_view[63:32];
      A_GBASE_LO: rdata_o = cfg_base[31:0];
      A_GBASE_HI: rdata_o = cfg_base[63:32];
      A_CTX_LO:   rdata_o = cbase[31:0];
      A_CTX_HI:   rdata_o = cbase[63:32];
      A_CTX_DW:   rdata_o = cdw;
      default:    rdata_o = '0;
    endcase
  end

  // R12
  hdr_rb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_SET_HDR) |=> set_hdr == $past(wdata_i));

endmodule

// File: tb/sim_ds_regfile.sv
`timescale 1ns/1ps
module sim_ds_regfile;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ds_regfile u0 (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .addr_i (addr),
    .wdata_i(wdata),
    .we_i   (we),
    .rdata_o(rdata)
  );

  typedef struct packed {
    logic        we;
    logic [3:0]  wa;
    logic [31:0] wd;
    logic [3:0]  ra;
    logic [31:0] ex;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 40;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 4'd0, 32'h0530_1234, 4'd2, 32'h0000_0020, 4'd3},   // R3
    '{1'b1, 4'd0, 32'h0170_00FF, 4'd2, 32'h0000_0022, 4'd3},   // R3
    '{1'b1, 4'd0, 32'hFFFF_FFFF, 4'd0, 32'hFFFF_FFFF, 4'd12},  // R12
    '{1'b0, 4'd0, 32'h0,         4'd2, 32'h8000_0022, 4'd3},   // R3
    '{1'b1, 4'd2, 32'h0000_0F00, 4'd2, 32'h0000_0F00, 4'd4},   // R4
    '{1'b1, 4'd0, 32'h0530_1234, 4'd2, 32'h0000_0F20, 4'd3},   // R3
    '{1'b1, 4'd6, 32'hAAAA_0005, 4'd6, 32'hAAAA_0005, 4'd5},   // R5
    '{1'b1, 4'd7, 32'hBBBB_0005, 4'd7, 32'hBBBB_0005, 4'd5},   // R5
    '{1'b1, 4'd8, 32'h1111_0000, 4'd8, 32'h1111_0000, 4'd7},   // R7
    '{1'b1, 4'd9, 32'h2222_0000, 4'd9, 32'h2222_0000, 4'd7},   // R7
    '{1'b1, 4'd10,32'h0000_0033, 4'd10,32'h0000_0033, 4'd7},   // R7
    '{1'b1, 4'd1, 32'h0000_0005, 4'd3, 32'h0530_1234, 4'd6},   // R6
    '{1'b0, 4'd0, 32'h0,         4'd4, 32'hAAAA_0005, 4'd6},   // R6
    '{1'b0, 4'd0, 32'h0,         4'd5, 32'hBBBB_0005, 4'd6},   // R6
    '{1'b0, 4'd0, 32'h0,         4'd10,32'h0000_0000, 4'd8},   // R8
    '{1'b0, 4'd0, 32'h0,         4'd8, 32'h0000_0000, 4'd8},   // R8
    '{1'b0, 4'd0, 32'h0,         4'd1, 32'h0000_0005, 4'd8},   // R8
    '{1'b1, 4'd1, 32'h0000_0000, 4'd8, 32'h1111_0000, 4'd7},   // R7
    '{1'b0, 4'd0, 32'h0,         4'd9, 32'h2222_0000, 4'd7},   // R7
    '{1'b0, 4'd0, 32'h0,         4'd10,32'h0000_0033, 4'd7},   // R7
    '{1'b0, 4'd0, 32'h0,         4'd3, 32'h0000_0000, 4'd6},   // R6
    '{1'b1, 4'd1, 32'h0000_0025, 4'd1, 32'h0000_0005, 4'd10},  // R10
    '{1'b0, 4'd0, 32'h0,         4'd10,32'h0000_0000, 4'd10},  // R10
    '{1'b1, 4'd10,32'h0000_0077, 4'd10,32'h0000_0077, 4'd9},   // R9
    '{1'b1, 4'd1, 32'h0000_0005, 4'd10,32'h0000_0077, 4'd9},   // R9
    '{1'b1, 4'd1, 32'h0000_0000, 4'd10,32'h0000_0033, 4'd7},   // R7
    '{1'b1, 4'd1, 32'h0000_0005, 4'd10,32'h0000_0077, 4'd7},   // R7
    '{1'b1, 4'd3, 32'h0000_DEAD, 4'd3, 32'h0530_1234, 4'd11},  // R11
    '{1'b1, 4'd4, 32'h0000_0000, 4'd4, 32'hAAAA_0005, 4'd11},  // R11
    '{1'b1, 4'd15,32'h0000_0001, 4'd15,32'h0000_0000, 4'd11},  // R11
    '{1'b0, 4'd0, 32'h0,         4'd2, 32'h0000_0F20, 4'd11},  // R11
    '{1'b1, 4'd1, 32'h0000_0001, 4'd3, 32'h0170_00FF, 4'd2},   // R2
    '{1'b1, 4'd1, 32'h0000_001F, 4'd3, 32'h1F70_FFFF, 4'd2},   // R2
    '{1'b1, 4'd0, 32'h0530_0042, 4'd0, 32'h0530_0042, 4'd12},  // R12
    '{1'b1, 4'd1, 32'h0000_0005, 4'd3, 32'h0530_0042, 4'd2},   // R2
    '{1'b0, 4'd0, 32'h0,         4'd4, 32'hAAAA_0005, 4'd5},   // R5
    '{1'b1, 4'd0, 32'h0100_0000, 4'd0, 32'h0100_0000, 4'd12},  // R12
    '{1'b1, 4'd6, 32'hCCCC_0001, 4'd6, 32'hCCCC_0001, 4'd5},   // R5
    '{1'b1, 4'd1, 32'h0000_0001, 4'd4, 32'hCCCC_0001, 4'd5},   // R5
    '{1'b1, 4'd1, 32'h0000_0005, 4'd4, 32'hAAAA_0005, 4'd5}    // R5
  };

  task automatic check(input int rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: got %08h expected %08h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input int rq);
    addr = a;
    #1;
    check(rq, rdata, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    we = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    do_reset();
    // R1: reset state of every readable address
    for (int a = 0; a < 16; a++) rd_chk(4'(a), 32'h0, 1);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].we) wr(TBL[i].wa, TBL[i].wd);
      else @(negedge clk);
      rd_chk(TBL[i].ra, TBL[i].ex, int'(TBL[i].rq));
    end

    // R11: repeated reads leave values intact
    @(negedge clk);
    rd_chk(4'd10, 32'h0000_0077, 11);
    @(negedge clk);
    rd_chk(4'd10, 32'h0000_0077, 11);

    // R1: reset clears stored group contents and mask
    do_reset();
    rd_chk(4'd2, 32'h0, 1);
    wr(4'd1, 32'h0000_0005);
    rd_chk(4'd3, 32'h0, 1);
    rd_chk(4'd4, 32'h0, 1);
    rd_chk(4'd5, 32'h0, 1);
    rd_chk(4'd10, 32'h0, 1);
    wr(4'd1, 32'h0000_0000);
    rd_chk(4'd8, 32'h0, 1);

    // R9: reselect after reset right away keeps a fresh live count
    wr(4'd10, 32'h0000_0099);
    wr(4'd1, 32'h0000_0000);
    rd_chk(4'd10, 32'h0000_0099, 9);

    done = 1'b1;
    finish_run();
  end

endmodule